// File: doc/BRIEF.md
# Power-Down Wake-Up Sequencer

This controller governs how a chip leaves its deep power-down state. Two exits exist. An asynchronous hardware reset always works. An active-low wake pin works only when the wake-enable bit was set at the moment power-down began. A wake through the pin runs in fixed phases, each with its own exit condition. First the pin is qualified on a slow RC-clock tick. Next the sequencer waits for the oscillator monitor to report a stable main clock. A settle delay follows. Last, a wake interrupt with a fixed vector is raised.

Until software signals the interrupt return, the timers, serial interfaces and watchdog are held by a freeze output. The wake-enable bit changes only when a register-map select input is high during the write. The effective pin level combines the pin itself with its port output latch. A latch value of 0 therefore looks like a low pin, and the wake begins as soon as power-down is entered.

Top module: `pdWakeSeq`

## Requirements
- R1: Reset (`rstN` low) acts asynchronously in every state. It gives state RUN (code 0), `wakeEnable` 0, `rcOscEn` 1, `mainOscEn` 1, `perFreeze` 0, `wakeIrq` 0 and `irqVector` 0.
- R2: `wakeEnable` takes `wakeEnData` at a clock edge only when `wakeEnWr` and `mapSel` are both 1. In every other case it holds its value.
- R3: In RUN, a `pdEnter` pulse moves the state to PD (code 1) at the next edge. In PD both `rcOscEn` and `mainOscEn` are 0.
- R4: If `wakeEnable` was 0 when PD was entered, PD is left only by reset. Pin activity, RC ticks and a later write of `wakeEnable` do not change that.
- R5: If PD was entered with `wakeEnable` 1, an effective pin low moves the state to LATCH (code 2) at the next edge. The effective pin is low when `wakePinN` is 0 or `pinLatch` is 0. In LATCH, `rcOscEn` is 1 and `mainOscEn` is 0.
- R6: In LATCH the pin is examined only at edges where `rcTick` is 1. After `LATCH_TICKS` consecutive low samples the state moves to OSC_WAIT (code 3), where `mainOscEn` is 1.
- R7: A high sample on an `rcTick` edge in LATCH returns the state to PD, and `rcOscEn` is 0 again.
- R8: OSC_WAIT holds while `oscStable` is 0. The edge that sees `oscStable` 1 enters SETTLE (code 4). SETTLE lasts exactly `SETTLE_CYCLES` clock cycles and then enters WAKE_IRQ (code 5).
- R9: In WAKE_IRQ, `wakeIrq` is 1 and `irqVector` is 0x007B. An `irqRet` pulse returns the state to RUN at the next edge, with `perFreeze` at 0.
- R10: `perFreeze` is 1 in every state other than RUN.
- R11: With `wakeEnable` 1 and `pinLatch` 0 at entry, the state goes to LATCH one edge after reaching PD, even while `wakePinN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| pdEnter | input | 1 | Power-down entry strobe |
| mapSel | input | 1 | Register-map select that gates enable writes |
| wakeEnWr | input | 1 | Write strobe for the wake-enable bit |
| wakeEnData | input | 1 | Value written to the wake-enable bit |
| wakePinN | input | 1 | Active-low external wake pin |
| pinLatch | input | 1 | Port output latch value for the wake pin |
| rcTick | input | 1 | One-cycle tick of the RC oscillator clock |
| oscStable | input | 1 | Main oscillator stable flag from the monitor |
| irqRet | input | 1 | Interrupt-return strobe from the wake handler |
| rcOscEn | output | 1 | RC oscillator enable |
| mainOscEn | output | 1 | Main oscillator enable |
| perFreeze | output | 1 | Peripheral freeze |
| wakeIrq | output | 1 | Wake interrupt request |
| irqVector | output | 16 | Wake interrupt vector (0x007B while requesting) |
| state | output | 3 | Sequencer state code |
| wakeEnable | output | 1 | Current wake-enable bit |

## Verification
Every output comes from registers, so each one follows its stimulus by one clock edge. A strobe driven after one falling edge shows its effect at the next falling edge. SETTLE adds `SETTLE_CYCLES` edges, and LATCH advances only on edges that carry `rcTick`. A behavioural reference model updates on the same rising edges as the design. It is compared with every output at each falling edge. Directed checks sample at those same falling edges, at the count of edges worked out from the requirements: for example, still SETTLE after 19 edges and WAKE_IRQ after 20.

// File: rtl/pdws_pkg.sv
package pdws_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_PD      = 3'd1,
    ST_LATCH   = 3'd2,
    ST_OSCWAIT = 3'd3,
    ST_SETTLE  = 3'd4,
    ST_WAKEIRQ = 3'd5
  } pdwsState_e;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic armLoad;
  } pdwsStrb_t;

  localparam logic [15:0] WAKE_VECTOR = 16'h007B;
endpackage

// File: rtl/pdws_datapath.sv
module pdws_datapath
  import pdws_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  pdwsStrb_t        strb,
  input  logic             mapSel,
  input  logic             wakeEnWr,
  input  logic             wakeEnData,
  input  logic             wakePinN,
  input  logic             pinLatch,
  output logic             wakeEnable,
  output logic             armed,
  output logic             pinLow,
  output logic [CNT_W-1:0] cnt
);
  // effective pin: a cleared output latch pulls the pin low
  assign pinLow = ~(wakePinN & pinLatch);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeEnable <= 1'b0;
    end else if (wakeEnWr && mapSel) begin
      wakeEnable <= wakeEnData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (strb.armLoad) begin
      armed <= wakeEnable;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.cntClr) begin
      cnt <= '0;
    end else if (strb.cntInc) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pdws_control.sv
module pdws_control
  import pdws_pkg::*;
#(
  parameter int LATCH_TICKS   = 4,
  parameter int SETTLE_CYCLES = 20,
  parameter int CNT_W         = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pdEnter,
  input  logic             rcTick,
  input  logic             oscStable,
  input  logic             irqRet,
  input  logic             armed,
  input  logic             pinLow,
  input  logic [CNT_W-1:0] cnt,
  output pdwsStrb_t        strb,
  output pdwsState_e       curState,
  output logic             rcOscEn,
  output logic             mainOscEn,
  output logic             perFreeze,
  output logic             wakeIrq,
  output logic [15:0]      irqVector
);
  localparam logic [CNT_W-1:0] LATCH_LAST  = CNT_W'(LATCH_TICKS - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);

  pdwsState_e nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_RUN;
    else       curState <= nextState;
  end

  always_comb begin
    nextState = curState;
    strb      = '0;
    unique case (curState)
      ST_RUN: begin
        if (pdEnter) begin
          nextState    = ST_PD;
          strb.armLoad = 1'b1;
        end
      end
      ST_PD: begin
        if (armed && pinLow) begin
          nextState   = ST_LATCH;
          strb.cntClr = 1'b1;
        end
      end
      ST_LATCH: begin
        if (rcTick) begin
          if (!pinLow) begin
            nextState = ST_PD;
          end else if (cnt == LATCH_LAST) begin
            nextState   = ST_OSCWAIT;
            strb.cntClr = 1'b1;
          end else begin
            strb.cntInc = 1'b1;
          end
        end
      end
      ST_OSCWAIT: begin
        if (oscStable) begin
          nextState   = ST_SETTLE;
          strb.cntClr = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (cnt == SETTLE_LAST) begin
          nextState   = ST_WAKEIRQ;
          strb.cntClr = 1'b1;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      ST_WAKEIRQ: begin
        if (irqRet) nextState = ST_RUN;
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_comb begin
    rcOscEn   = 1'b1;
    mainOscEn = 1'b1;
    perFreeze = (curState != ST_RUN);
    wakeIrq   = (curState == ST_WAKEIRQ);
    irqVector = wakeIrq ? WAKE_VECTOR : 16'h0000;
    if (curState == ST_PD) begin
      rcOscEn   = 1'b0;
      mainOscEn = 1'b0;
    end else if (curState == ST_LATCH) begin
      mainOscEn = 1'b0;
    end
  end
endmodule

// File: rtl/pdWakeSeq.sv
module pdWakeSeq
  import pdws_pkg::*;
#(
  parameter int LATCH_TICKS   = 4,
  parameter int SETTLE_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pdEnter,
  input  logic        mapSel,
  input  logic        wakeEnWr,
  input  logic        wakeEnData,
  input  logic        wakePinN,
  input  logic        pinLatch,
  input  logic        rcTick,
  input  logic        oscStable,
  input  logic        irqRet,
  output logic        rcOscEn,
  output logic        mainOscEn,
  output logic        perFreeze,
  output logic        wakeIrq,
  output logic [15:0] irqVector,
  output logic [2:0]  state,
  output logic        wakeEnable
);
  localparam int CNT_MAX = (LATCH_TICKS > SETTLE_CYCLES) ? LATCH_TICKS : SETTLE_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  pdwsStrb_t        strb;
  pdwsState_e       curState;
  logic             armed;
  logic             pinLow;
  logic [CNT_W-1:0] cnt;

  pdws_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mapSel(mapSel),
    .wakeEnWr(wakeEnWr), .wakeEnData(wakeEnData), .wakePinN(wakePinN),
    .pinLatch(pinLatch), .wakeEnable(wakeEnable), .armed(armed),
    .pinLow(pinLow), .cnt(cnt)
  );

  pdws_control #(
    .LATCH_TICKS(LATCH_TICKS), .SETTLE_CYCLES(SETTLE_CYCLES), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .pdEnter(pdEnter), .rcTick(rcTick),
    .oscStable(oscStable), .irqRet(irqRet), .armed(armed), .pinLow(pinLow),
    .cnt(cnt), .strb(strb), .curState(curState), .rcOscEn(rcOscEn),
    .mainOscEn(mainOscEn), .perFreeze(perFreeze), .wakeIrq(wakeIrq),
    .irqVector(irqVector)
  );

  assign state = curState;
endmodule

// File: rtl/pdWakeSeqChk.sv
module pdWakeSeqChk (
  input logic        clk,
  input logic        rstN,
  input logic        pdEnter,
  input logic        mapSel,
  input logic        wakeEnWr,
  input logic        rcTick,
  input logic        oscStable,
  input logic        irqRet,
  input logic        rcOscEn,
  input logic        mainOscEn,
  input logic        perFreeze,
  input logic        wakeIrq,
  input logic [15:0] irqVector,
  input logic [2:0]  state,
  input logic        wakeEnable,
  input logic        armed
);
  AST_ENTER_PD: assert property (@(posedge clk) disable iff (!rstN)
    (state == 3'd0 && pdEnter) |=> (state == 3'd1)); // R3
  AST_PD_OSC_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (state == 3'd1) |-> (!rcOscEn && !mainOscEn)); // R3
  AST_WEN_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!mapSel || !wakeEnWr) |=> $stable(wakeEnable)); // R2
  AST_DISARMED_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (state == 3'd1 && !armed) |=> (state == 3'd1)); // R4
  AST_LATCH_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (state == 3'd2 && !rcTick) |=> (state == 3'd2)); // R6
  AST_OSC_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == 3'd3 && !oscStable) |=> (state == 3'd3)); // R8
  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |-> (irqVector == 16'h007B)); // R9
  AST_IRQ_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (state == 3'd5 && irqRet) |=> (state == 3'd0 && !perFreeze)); // R9
  AST_FREEZE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (state != 3'd0) |-> perFreeze); // R10
endmodule

bind pdWakeSeq pdWakeSeqChk u_chk (.*);

// File: tb/sim_pdWakeSeq.sv
`timescale 1ns/1ps
module sim_pdWakeSeq;
  localparam int LT = 4;
  localparam int SC = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdEnter = 0, mapSel = 0, wakeEnWr = 0, wakeEnData = 0;
  logic wakePinN = 1, pinLatch = 1, rcTick = 0, oscStable = 0, irqRet = 0;
  logic rcOscEn, mainOscEn, perFreeze, wakeIrq, wakeEnable;
  logic [15:0] irqVector;
  logic [2:0] state;

  int nChk = 0;
  int nFail = 0;
  bit cmpOn = 0;

  always #5 clk = ~clk;

  pdWakeSeq #(.LATCH_TICKS(LT), .SETTLE_CYCLES(SC)) u0 (
    .clk(clk), .rstN(rstN), .pdEnter(pdEnter), .mapSel(mapSel),
    .wakeEnWr(wakeEnWr), .wakeEnData(wakeEnData), .wakePinN(wakePinN),
    .pinLatch(pinLatch), .rcTick(rcTick), .oscStable(oscStable),
    .irqRet(irqRet), .rcOscEn(rcOscEn), .mainOscEn(mainOscEn),
    .perFreeze(perFreeze), .wakeIrq(wakeIrq), .irqVector(irqVector),
    .state(state), .wakeEnable(wakeEnable)
  );

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mSt, mEn, mArm, mCnt, mLow;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; mEn = 0; mArm = 0; mCnt = 0;
    end else begin
      mLow = (wakePinN && pinLatch) ? 0 : 1;
      if (mSt == 0 && pdEnter) begin mArm = mEn; mSt = 1; end
      else if (mSt == 1) begin
        if (mArm == 1 && mLow == 1) begin mSt = 2; mCnt = 0; end
      end else if (mSt == 2) begin
        if (rcTick) begin
          if (mLow == 0) mSt = 1;
          else begin
            mCnt++;
            if (mCnt >= LT) begin mSt = 3; mCnt = 0; end
          end
        end
      end else if (mSt == 3) begin
        if (oscStable) begin mSt = 4; mCnt = 0; end
      end else if (mSt == 4) begin
        mCnt++;
        if (mCnt >= SC) begin mSt = 5; mCnt = 0; end
      end else if (mSt == 5) begin
        if (irqRet) mSt = 0;
      end
      if (wakeEnWr && mapSel) mEn = wakeEnData ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      chk("R3 state", int'(state), mSt);
      chk("R3 rcOscEn", int'(rcOscEn), (mSt == 1) ? 0 : 1);
      chk("R5 mainOscEn", int'(mainOscEn), (mSt == 1 || mSt == 2) ? 0 : 1);
      chk("R10 perFreeze", int'(perFreeze), (mSt != 0) ? 1 : 0);
      chk("R9 wakeIrq", int'(wakeIrq), (mSt == 5) ? 1 : 0);
      chk("R9 irqVector", int'(irqVector), (mSt == 5) ? 16'h007B : 0);
      chk("R2 wakeEnable", int'(wakeEnable), mEn);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rcPulse();
    @(negedge clk) rcTick = 1;
    @(negedge clk) rcTick = 0;
  endtask

  task automatic writeEn(bit sel, bit val);
    @(negedge clk) begin mapSel = sel; wakeEnWr = 1; wakeEnData = val; end
    @(negedge clk) begin mapSel = 0; wakeEnWr = 0; end
  endtask

  task automatic enterPd();
    @(negedge clk) pdEnter = 1;
    @(negedge clk) pdEnter = 0;
  endtask

  task automatic doReset();
    #2 rstN = 0;
    #1;
    chk("R1 async state", int'(state), 0);
    chk("R1 wakeEnable", int'(wakeEnable), 0);
    @(negedge clk) rstN = 1;
  endtask

  initial begin
    #200000000;
    nChk++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    idle(2);
    chk("R1 state", int'(state), 0);
    chk("R1 rcOscEn", int'(rcOscEn), 1);
    chk("R1 mainOscEn", int'(mainOscEn), 1);
    chk("R1 perFreeze", int'(perFreeze), 0);
    chk("R1 wakeIrq", int'(wakeIrq), 0);
    chk("R1 irqVector", int'(irqVector), 0);
    @(negedge clk) rstN = 1;
    cmpOn = 1;
    idle(2);

    // R2: map select gates writes
    writeEn(0, 1);
    chk("R2 write without map", int'(wakeEnable), 0);
    writeEn(1, 1);
    chk("R2 write with map", int'(wakeEnable), 1);
    writeEn(1, 0);
    chk("R2 clear with map", int'(wakeEnable), 0);

    // R4: disarmed power-down ignores pin
    enterPd();
    chk("R3 in PD", int'(state), 1);
    chk("R3 rc off", int'(rcOscEn), 0);
    chk("R10 freeze in PD", int'(perFreeze), 1);
    @(negedge clk) wakePinN = 0;
    repeat (6) rcPulse();
    chk("R4 pin ignored", int'(state), 1);
    writeEn(1, 1);
    repeat (3) rcPulse();
    chk("R4 late enable ignored", int'(state), 1);
    @(negedge clk) wakePinN = 1;
    doReset();
    chk("R1 reset leaves PD", int'(state), 0);
    chk("R1 freeze released", int'(perFreeze), 0);

    // R5/R7: armed, short pulse rejected
    writeEn(1, 1);
    enterPd();
    idle(3);
    chk("R5 high pin keeps PD", int'(state), 1);
    @(negedge clk) wakePinN = 0;
    @(negedge clk);
    chk("R5 enter LATCH", int'(state), 2);
    chk("R5 rc on", int'(rcOscEn), 1);
    chk("R5 main off", int'(mainOscEn), 0);
    rcPulse(); rcPulse();
    @(negedge clk) wakePinN = 1;
    rcPulse();
    chk("R7 short pulse to PD", int'(state), 1);
    chk("R7 rc off again", int'(rcOscEn), 0);

    // R6/R8/R9: full wake
    @(negedge clk) wakePinN = 0;
    @(negedge clk);
    chk("R6 LATCH again", int'(state), 2);
    idle(5);
    chk("R6 no tick no advance", int'(state), 2);
    repeat (LT - 1) rcPulse();
    chk("R6 before last tick", int'(state), 2);
    rcPulse();
    chk("R6 OSC_WAIT", int'(state), 3);
    chk("R6 main on", int'(mainOscEn), 1);
    @(negedge clk) wakePinN = 1;
    idle(8);
    chk("R8 waits for stable", int'(state), 3);
    @(negedge clk) oscStable = 1;
    @(negedge clk);
    chk("R8 SETTLE", int'(state), 4);
    idle(SC - 1);
    chk("R8 still SETTLE", int'(state), 4);
    idle(1);
    chk("R8 WAKE_IRQ", int'(state), 5);
    chk("R9 irq", int'(wakeIrq), 1);
    chk("R9 vector", int'(irqVector), 16'h007B);
    chk("R10 freeze in IRQ", int'(perFreeze), 1);
    idle(4);
    chk("R9 irq held", int'(state), 5);
    @(negedge clk) irqRet = 1;
    @(negedge clk) irqRet = 0;
    chk("R9 back to RUN", int'(state), 0);
    chk("R9 freeze off", int'(perFreeze), 0);
    chk("R9 irq off", int'(wakeIrq), 0);

    // R11: cleared port latch starts wake at once
    @(negedge clk) begin pinLatch = 0; oscStable = 0; end
    enterPd();
    chk("R11 PD first", int'(state), 1);
    @(negedge clk);
    chk("R11 LATCH immediately", int'(state), 2);
    repeat (LT) rcPulse();
    chk("R11 OSC_WAIT", int'(state), 3);
    @(negedge clk) pinLatch = 1;
    doReset();
    chk("R1 reset from OSC_WAIT", int'(state), 0);
    chk("R1 enable cleared", int'(wakeEnable), 0);
    idle(3);

    cmpOn = 0;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule